// File: doc/BRIEF.md
# Bus Transmission Mode Detector

This block decides which signalling mode a parallel bus is running in by watching the digitized voltage of the bus mode-sense line. Each incoming sample is a signed millivolt value with a valid strobe. The block sorts each sample into one of three voltage bands: single-ended, low-voltage differential or high-voltage differential. A sample that falls in none of the bands is undefined. The latest sorted value is always shown on a raw output.

The raw value is noisy and can be transient. For this reason a separate qualified mode output is kept. It moves to a new mode only after that mode has been seen without a break for a qualification window, nominally 100 ms. The window is counted in clock cycles, derived from a clock-frequency parameter and a window-length parameter. On the cycle the qualified mode moves, a one-cycle change pulse is raised.

Two independent channels, A side and B side, are built from the same channel logic. Each channel has its own inputs, outputs, candidate and timer.

Top module: `bus_mode_detect`

## Requirements
- R1: A valid sample from -350 mV to +500 mV, both ends included, sets the raw mode to single-ended, code 2'b01.
- R2: A valid sample from +700 mV to +1900 mV, both ends included, sets the raw mode to low-voltage differential, code 2'b10.
- R3: A valid sample from +2400 mV to +5500 mV, both ends included, sets the raw mode to high-voltage differential, code 2'b11.
- R4: A valid sample in any other range sets the raw mode to undefined, code 2'b00. The raw mode is registered: it appears one cycle after the edge that captures a valid sample, and it holds while the strobe is low.
- R5: During and after reset, the qualified mode is single-ended (2'b01), the raw mode is undefined (2'b00) and the change pulse is low. The qualified mode is never undefined.
- R6: Let W be the window in cycles (W = CLK_HZ/1000 * WINDOW_MS, at least 2). If the raw mode shows a defined mode other than the qualified mode from clock edge E onward, the qualified mode takes that value at edge E+W, and not before.
- R7: A raw undefined value restarts any pending qualification and leaves the qualified mode unchanged.
- R8: A raw value equal to the qualified mode cancels the pending candidate and its timer.
- R9: If the raw mode switches to a different non-current defined mode before the window ends, the timer restarts for the new candidate.
- R10: The change pulse is high for exactly the one cycle after the edge at which the qualified mode updates, and at no other time.
- R11: The A and B channels classify and qualify independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sample_mv | input | SAMPLE_W | A-side sample, signed millivolts |
| a_sample_vld | input | 1 | A-side sample strobe |
| b_sample_mv | input | SAMPLE_W | B-side sample, signed millivolts |
| b_sample_vld | input | 1 | B-side sample strobe |
| a_mode | output | 2 | A-side qualified mode |
| a_mode_chg | output | 1 | A-side one-cycle change pulse |
| a_raw_mode | output | 2 | A-side instantaneous classification |
| b_mode | output | 2 | B-side qualified mode |
| b_mode_chg | output | 1 | B-side one-cycle change pulse |
| b_raw_mode | output | 2 | B-side instantaneous classification |

## Verification
The hardest case to reach is an interruption that lands one cycle before the window would have expired. This tests whether the timer really restarts, or whether a stale count lets a later candidate qualify early. Directed sequences place an undefined sample, a matching sample or a different candidate exactly at edge W-1 after the first sighting. The bench then checks the qualified mode on both sides of the restarted deadline. Random runs hold each band for spans that are sometimes shorter and sometimes longer than W, with sparse strobes. A cycle-accurate bench model checks every output on every cycle.

// File: rtl/msense_pkg.sv
package msense_pkg;
  typedef enum logic [1:0] {
    MODE_UNDEF = 2'b00,
    MODE_SE    = 2'b01,
    MODE_LVD   = 2'b10,
    MODE_HVD   = 2'b11
  } mode_t;

  localparam int NUM_BANDS = 3;

  // band limits in millivolts, inclusive; index b maps to code b+1
  localparam int BAND_LO_MV [NUM_BANDS] = '{-350,  700, 2400};
  localparam int BAND_HI_MV [NUM_BANDS] = '{ 500, 1900, 5500};
endpackage

// File: rtl/msense_band_classifier.sv
module msense_band_classifier
  import msense_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_mv,
  input  logic                       sample_vld,
  output mode_t                      raw_mode
);
  logic [NUM_BANDS-1:0] band_hit;
  mode_t                cls;

  // one window comparator per band
  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam int LO = BAND_LO_MV[b];
    localparam int HI = BAND_HI_MV[b];
    assign band_hit[b] = (int'(sample_mv) >= LO) && (int'(sample_mv) <= HI);
  end

  always_comb begin
    cls = MODE_UNDEF;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (band_hit[b]) cls = mode_t'(b + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             raw_mode <= MODE_UNDEF;
    else if (sample_vld) raw_mode <= cls;
  end

  // bands never overlap, so at most one comparator fires
  assert_band_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(band_hit));

  // raw value holds between strobes
  assert_raw_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(sample_vld) |-> $stable(raw_mode));
endmodule

// File: rtl/msense_persist_qual.sv
module msense_persist_qual
  import msense_pkg::*;
#(
  parameter int WIN_CYCLES = 10_000_000
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t raw_mode,
  output mode_t mode_q,
  output logic  mode_chg
);
  localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYCLES - 1);

  mode_t            cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_other;
  logic             expire;

  assign is_other = (raw_mode != MODE_UNDEF) && (raw_mode != mode_q);
  assign expire   = is_other && (raw_mode == cand_q) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_SE;
      cand_q   <= MODE_UNDEF;
      cnt_q    <= '0;
      mode_chg <= 1'b0;
    end else begin
      mode_chg <= 1'b0;
      if (!is_other) begin
        cand_q <= MODE_UNDEF;
        cnt_q  <= '0;
      end else if (raw_mode != cand_q) begin
        cand_q <= raw_mode;
        cnt_q  <= CNT_W'(1);
      end else if (expire) begin
        mode_q   <= raw_mode;
        mode_chg <= 1'b1;
        cand_q   <= MODE_UNDEF;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_mode_defined_R5: assert property (@(posedge clk) disable iff (rst)
    mode_q != MODE_UNDEF);

  assert_update_pulses_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> mode_chg);

  assert_pulse_means_update_R10: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> (mode_q != $past(mode_q)));

  assert_new_mode_was_seen_R6: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> ($past(raw_mode) == mode_q));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);

  assert_undef_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    (raw_mode == MODE_UNDEF) |=> (cnt_q == '0 && $stable(mode_q)));

  assert_match_cancels_R8: assert property (@(posedge clk) disable iff (rst)
    (raw_mode == mode_q) |=> (cand_q == MODE_UNDEF));
endmodule

// File: rtl/msense_channel.sv
module msense_channel
  import msense_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int WIN_CYCLES = 10_000_000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_mv,
  input  logic                       sample_vld,
  output mode_t                      raw_mode,
  output mode_t                      mode_q,
  output logic                       mode_chg
);
  msense_band_classifier #(.SAMPLE_W(SAMPLE_W)) u_cls (
    .clk        (clk),
    .rst        (rst),
    .sample_mv  (sample_mv),
    .sample_vld (sample_vld),
    .raw_mode   (raw_mode)
  );

  msense_persist_qual #(.WIN_CYCLES(WIN_CYCLES)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .raw_mode (raw_mode),
    .mode_q   (mode_q),
    .mode_chg (mode_chg)
  );
endmodule

// File: rtl/bus_mode_detect.sv
module bus_mode_detect
  import msense_pkg::*;
#(
  parameter int SAMPLE_W  = 14,
  parameter int CLK_HZ    = 100_000_000,
  parameter int WINDOW_MS = 100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] a_sample_mv,
  input  logic                       a_sample_vld,
  input  logic signed [SAMPLE_W-1:0] b_sample_mv,
  input  logic                       b_sample_vld,
  output logic [1:0]                 a_mode,
  output logic                       a_mode_chg,
  output logic [1:0]                 a_raw_mode,
  output logic [1:0]                 b_mode,
  output logic                       b_mode_chg,
  output logic [1:0]                 b_raw_mode
);
  localparam int NUM_CH     = 2;
  localparam int WIN_CYCLES = (CLK_HZ / 1000) * WINDOW_MS;

  logic signed [SAMPLE_W-1:0] smp [NUM_CH];
  logic                       vld [NUM_CH];
  mode_t                      raw [NUM_CH];
  mode_t                      qm  [NUM_CH];
  logic                       chg [NUM_CH];

  assign smp[0] = a_sample_mv;
  assign vld[0] = a_sample_vld;
  assign smp[1] = b_sample_mv;
  assign vld[1] = b_sample_vld;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    msense_channel #(
      .SAMPLE_W   (SAMPLE_W),
      .WIN_CYCLES (WIN_CYCLES)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .sample_mv  (smp[c]),
      .sample_vld (vld[c]),
      .raw_mode   (raw[c]),
      .mode_q     (qm[c]),
      .mode_chg   (chg[c])
    );
  end

  assign a_mode     = qm[0];
  assign a_mode_chg = chg[0];
  assign a_raw_mode = raw[0];
  assign b_mode     = qm[1];
  assign b_mode_chg = chg[1];
  assign b_raw_mode = raw[1];
endmodule

// File: tb/bus_mode_detect_tb.sv
module bus_mode_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW         = 14;
  localparam int CLK_HZ     = 1000;
  localparam int WINDOW_MS  = 12;
  localparam int WIN        = (CLK_HZ / 1000) * WINDOW_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [SW-1:0] a_mv = '0, b_mv = '0;
  logic a_v = 1'b0, b_v = 1'b0;
  logic [1:0] a_mode, a_raw, b_mode, b_raw;
  logic a_chg, b_chg;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_mode_detect #(.SAMPLE_W(SW), .CLK_HZ(CLK_HZ), .WINDOW_MS(WINDOW_MS)) u_dut (
    .clk(clk), .rst(rst),
    .a_sample_mv(a_mv), .a_sample_vld(a_v),
    .b_sample_mv(b_mv), .b_sample_vld(b_v),
    .a_mode(a_mode), .a_mode_chg(a_chg), .a_raw_mode(a_raw),
    .b_mode(b_mode), .b_mode_chg(b_chg), .b_raw_mode(b_raw)
  );

  // band codes per R1..R4
  function automatic logic [1:0] classify(int mv);
    if (mv >= -350 && mv <= 500)  return 2'b01;
    if (mv >= 700  && mv <= 1900) return 2'b10;
    if (mv >= 2400 && mv <= 5500) return 2'b11;
    return 2'b00;
  endfunction

  function automatic string raw_tag(logic [1:0] m);
    case (m)
      2'b01:   return "R1";
      2'b10:   return "R2";
      2'b11:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle model built from R4, R6..R10
  logic [1:0] m_raw [2];
  logic [1:0] m_mode[2];
  logic [1:0] m_cand[2];
  logic       m_chg [2];
  int         m_run [2];

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rst) begin
        m_raw[c] = 2'b00; m_mode[c] = 2'b01; m_cand[c] = 2'b00;
        m_chg[c] = 1'b0;  m_run[c] = 0;
      end else begin
        logic [1:0] old;
        old = m_raw[c];
        m_chg[c] = 1'b0;
        if (old == 2'b00 || old == m_mode[c]) begin
          m_run[c] = 0; m_cand[c] = 2'b00;
        end else begin
          if (old != m_cand[c]) begin m_cand[c] = old; m_run[c] = 1; end
          else m_run[c]++;
          if (m_run[c] == WIN) begin
            m_mode[c] = old; m_chg[c] = 1'b1; m_run[c] = 0; m_cand[c] = 2'b00;
          end
        end
        if (c == 0 && a_v) m_raw[c] = classify(int'(a_mv));
        if (c == 1 && b_v) m_raw[c] = classify(int'(b_mv));
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(raw_tag(m_raw[0]), a_raw, m_raw[0]);
      check("R6 A mode", a_mode, m_mode[0]);
      check("R10 A pulse", a_chg, m_chg[0]);
      check(raw_tag(m_raw[1]), b_raw, m_raw[1]);
      check("R6 B mode", b_mode, m_mode[1]);
      check("R10 B pulse", b_chg, m_chg[1]);
    end
  end

  task automatic cyc(int amv, bit av, int bmv, bit bv);
    @(negedge clk);
    a_mv = SW'(amv); a_v = av;
    b_mv = SW'(bmv); b_v = bv;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(int'($urandom % 9000) - 1000, 0,
                                     int'($urandom % 9000) - 1000, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_v = 0; b_v = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int band_value(int band);
    case (band)
      1: return -350 + int'($urandom % 851);
      2: return 700  + int'($urandom % 1201);
      3: return 2400 + int'($urandom % 3101);
      default: begin
        case ($urandom % 4)
          0: return 501  + int'($urandom % 199);
          1: return 1901 + int'($urandom % 499);
          2: return -351 - int'($urandom % 3000);
          default: return 5501 + int'($urandom % 2000);
        endcase
      end
    endcase
  endfunction

  initial begin
    int bnd [12] = '{-350, 500, 700, 1900, 2400, 5500, -351, 501, 699, 1901, 2399, 5501};
    int aband, bband, arem, brem;
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    // R5: reset state, sampled while reset is still high
    check("R5 mode", a_mode, 1); check("R5 raw", a_raw, 0); check("R5 pulse", a_chg, 0);
    check("R5 B mode", b_mode, 1); check("R5 B raw", b_raw, 0);
    rst = 1'b0;

    // R1..R4 inclusive edges and the gaps
    foreach (bnd[i]) begin
      cyc(bnd[i], 1, bnd[11 - i], 1);
      cyc(0, 0, 0, 0);
      check(raw_tag(classify(bnd[i])), a_raw, classify(bnd[i]));
      check(raw_tag(classify(bnd[11 - i])), b_raw, classify(bnd[11 - i]));
    end
    idle(3);
    check("R4 raw held", a_raw, classify(bnd[11]));

    // R6 exact window
    do_reset();
    cyc(1000, 1, 0, 0);
    idle(WIN);
    check("R6 not early", a_mode, 1);
    check("R10 no pulse yet", a_chg, 0);
    idle(1);
    check("R6 updated", a_mode, 2);
    check("R10 pulse", a_chg, 1);
    idle(1);
    check("R10 pulse one cycle", a_chg, 0);

    // R7 undefined sample just before expiry
    cyc(3000, 1, 0, 0);
    idle(WIN - 2);
    cyc(600, 1, 0, 0);
    idle(WIN + 2);
    check("R7 mode kept", a_mode, 2);
    check("R7 raw undefined", a_raw, 0);

    // R8 matching sample cancels candidate
    cyc(3000, 1, 0, 0);
    idle(WIN - 2);
    cyc(1200, 1, 0, 0);
    idle(2);
    cyc(3000, 1, 0, 0);
    idle(WIN - 1);
    check("R8 timer cleared", a_mode, 2);
    idle(2);
    check("R8 later qualifies", a_mode, 3);

    // R9 candidate swap restarts timer
    cyc(200, 1, 0, 0);
    idle(WIN - 2);
    cyc(1000, 1, 0, 0);
    idle(WIN - 1);
    check("R9 restarted", a_mode, 3);
    idle(2);
    check("R9 new candidate wins", a_mode, 2);

    // R11 independent channels
    do_reset();
    cyc(4000, 1, 1500, 1);
    idle(WIN + 1);
    check("R11 A", a_mode, 3);
    check("R11 B", b_mode, 2);
    cyc(-100, 1, 0, 0);
    idle(WIN + 1);
    check("R11 A back to SE", a_mode, 1);
    check("R11 B untouched", b_mode, 2);

    // random phase
    aband = 0; bband = 0; arem = 0; brem = 0;
    for (int k = 0; k < 4000; k++) begin
      if (arem == 0) begin aband = int'($urandom % 4); arem = 1 + int'($urandom % (2 * WIN)); end
      if (brem == 0) begin bband = int'($urandom % 4); brem = 1 + int'($urandom % (2 * WIN)); end
      cyc(band_value(aband), bit'($urandom % 2), band_value(bband), bit'($urandom % 2));
      arem--; brem--;
    end
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule